// File: doc/BRIEF.md
# Video Sharpness Control Register Slave

This block is the two-wire serial control port of a video sharpness processor. A host writes five control registers: one byte of mode bits and four 6-bit strength settings (peaking, steepness, coring and line width). It reads back three bytes: a status byte and two 6-bit converter results. One strap input chooses between two slave addresses. The block runs on the system clock and oversamples SCL and SDA. It drives SDA only by pulling it low.

Writes start at any subaddress the host names and auto-increment. Reads cannot be addressed: every read transfer begins with the status byte and then walks through the result bytes. The status byte holds a power-loss flag that is cleared when the host reads it. A field-rate selector alternates the converter between its two channels. On each field flyback pulse, the code presented on `adc_code` is stored in the register of the active channel. If that store happens while the same register is being read on the bus, the register is marked invalid.

Top module: `vid_i2c_regfile`

## Requirements
- R1: The 7-bit slave address is {addr_strap, 1, addr_strap, 0, 0, 0, 0}, which gives a write byte of 40h with the strap low and E0h with it high. Any other address is not acknowledged and changes nothing.
- R2: In a write, the first byte after the address is the subaddress. Subaddresses 0 to 4 are acknowledged. A higher subaddress is not acknowledged, and the transfer then changes nothing.
- R3: Each data byte of a write is stored at the current subaddress, which then increments by one. A data byte that would land above subaddress 4 is not acknowledged and is not stored, and the pointer does not wrap to 0.
- R4: Subaddress 0 bit 0 drives ctl_stb, bit 1 ctl_ams, bit 2 ctl_fhs and bit 3 ctl_cfs; its bits 7:4 are not stored. Subaddresses 1, 2, 3 and 4 load peak_lvl, steep_lvl, coring_lvl and width_lvl from bits 5:0.
- R5: After reset all control bits and settings are 0, so ctl_stb = 0 selects pin control, and the slave still acknowledges its address.
- R6: Every read begins at read register 0, even when a subaddress was just written, and continues in the order 0, 1, 2, 0, ... for as long as the host acknowledges. A host NACK ends the transfer and releases SDA.
- R7: Read register 0 is {0000, id = 000, pdd}. pdd is 1 after reset and after every power_fail pulse. It is cleared when the status byte is taken for transmission, and a power_fail in that same cycle wins.
- R8: Read registers 1 and 2 are {0, dv, code[5:0]} for converter channels 0 and 1. Both read 00h after reset.
- R9: Each field_flyback pulse stores adc_code into the register of the channel shown on adc_ch (0 selects register 1), then toggles adc_ch. adc_ch is 0 after reset.
- R10: A flyback store into a register whose byte is on the bus stores dv = 0; this covers the span from the load of that byte up to the master's acknowledge bit. Any other store sets dv = 1. A byte already being shifted out keeps its old value.
- R11: START and STOP are recognised at any time. A repeated START begins a new transfer, and a STOP in the middle of a byte returns to idle with SDA released and nothing stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as sensed |
| sda_i | input | 1 | Serial data line as sensed |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_strap | input | 1 | Slave address select strap |
| power_fail | input | 1 | One-cycle pulse marking a supply interruption |
| field_flyback | input | 1 | One-cycle pulse at each field flyback |
| adc_code | input | 6 | Converter code to store at flyback |
| adc_ch | output | 1 | Converter channel currently selected |
| ctl_stb | output | 1 | Control source: 1 = registers, 0 = pins |
| ctl_ams | output | 1 | Luminance amplitude range select |
| ctl_fhs | output | 1 | Line frequency select |
| ctl_cfs | output | 1 | Contour filter select |
| peak_lvl | output | 6 | Peaking setting |
| steep_lvl | output | 6 | Steepness setting |
| coring_lvl | output | 6 | Coring setting |
| width_lvl | output | 6 | Line width setting |

## Verification
Two events can fall in the same cycle: the field-flyback store into a result register, and the bus read of that same register. The bench pulses field_flyback in the middle of a read byte. It then judges the outcome in two ways. The byte in flight must still carry the old code, and the next read must show the new code with dv cleared. A second case stores into the other channel's register while it is not yet on the bus. That byte must come out later in the same transfer with the new code and dv set. The power-loss flag sees the same kind of overlap between its set pulse and its clear-on-read, and the bench checks it by reading status after each pulse.

// File: rtl/vid_i2c_pkg.sv
package vid_i2c_pkg;

    localparam int SET_W    = 6;
    localparam int NUM_WR   = 5;
    localparam int NUM_ADC  = 2;
    localparam int NUM_RD   = 1 + NUM_ADC;
    localparam int IDX_W    = $clog2(NUM_WR + 1);
    localparam int CH_W     = (NUM_ADC > 1) ? $clog2(NUM_ADC) : 1;

    localparam logic [2:0] DEVICE_ID = 3'b000;

    localparam logic [IDX_W-1:0] SUB_CTL   = IDX_W'(0);
    localparam logic [IDX_W-1:0] SUB_PEAK  = IDX_W'(1);
    localparam logic [IDX_W-1:0] SUB_STEEP = IDX_W'(2);
    localparam logic [IDX_W-1:0] SUB_CORE  = IDX_W'(3);
    localparam logic [IDX_W-1:0] SUB_WIDTH = IDX_W'(4);
    localparam logic [IDX_W-1:0] SUB_LAST  = IDX_W'(NUM_WR - 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } bus_state_e;

    typedef struct packed {
        logic cfs;
        logic fhs;
        logic ams;
        logic stb;
    } ctl_bits_t;

    typedef struct packed {
        logic             dv;
        logic [SET_W-1:0] code;
    } adc_slot_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_ev_t;

    function automatic logic [6:0] slave_addr(input logic strap);
        return {strap, 1'b1, strap, 4'b0000};
    endfunction

    function automatic logic [IDX_W-1:0] rd_next(input logic [IDX_W-1:0] idx);
        return (idx >= IDX_W'(NUM_RD - 1)) ? '0 : idx + IDX_W'(1);
    endfunction

endpackage

// File: rtl/vid_i2c_line_sync.sv
module vid_i2c_line_sync
    import vid_i2c_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic [2:0] scl_p;
    logic [2:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[1:0], scl_i};
            sda_p <= {sda_p[1:0], sda_i};
        end
    end

    always_comb begin
        ev.rise  = scl_p[1] & ~scl_p[2];
        ev.fall  = ~scl_p[1] & scl_p[2];
        ev.start = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
        ev.stop  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
        ev.sda   = sda_p[1];
    end

endmodule

// File: rtl/vid_i2c_slave_fsm.sv
module vid_i2c_slave_fsm
    import vid_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    input  logic             strap,
    input  logic [7:0]       rd_byte,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             rd_load,
    output logic [IDX_W-1:0] rd_load_idx,
    output logic             rd_busy,
    output logic [IDX_W-1:0] rd_cur_idx
);

    bus_state_e       state;
    logic [3:0]       cnt;
    logic [7:0]       sh;
    logic [7:0]       tx;
    logic [IDX_W-1:0] wptr;
    logic             nack_q;

    logic byte_done;
    assign byte_done = ev.fall && (cnt == 4'd8);

    always_comb begin
        rd_load     = ev.fall && ((state == ST_ADDR_ACK && sh[0]) ||
                                  (state == ST_RACK && !nack_q));
        rd_load_idx = (state == ST_ADDR_ACK) ? '0 : rd_next(rd_cur_idx);
        rd_busy     = (state == ST_RDATA) || (state == ST_RACK);
        wr_en       = byte_done && (state == ST_WDATA) && (wptr <= SUB_LAST);
        wr_idx      = wptr;
        wr_data     = sh;
        sda_oe      = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) ||
                      (state == ST_WDATA_ACK) || (state == ST_RDATA && !tx[7]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            sh         <= '0;
            tx         <= '1;
            wptr       <= '0;
            nack_q     <= 1'b1;
            rd_cur_idx <= '0;
        end else if (ev.start) begin
            state <= ST_ADDR;
            cnt   <= '0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (ev.rise) begin
                        sh  <= {sh[6:0], ev.sda};
                        cnt <= cnt + 4'd1;
                    end else if (byte_done) begin
                        if (state == ST_ADDR) begin
                            state <= (sh[7:1] == slave_addr(strap)) ? ST_ADDR_ACK : ST_IDLE;
                        end else if (state == ST_SUB) begin
                            if (sh <= 8'(NUM_WR - 1)) begin
                                wptr  <= sh[IDX_W-1:0];
                                state <= ST_SUB_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            if (wptr <= SUB_LAST) begin
                                wptr  <= wptr + IDX_W'(1);
                                state <= ST_WDATA_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.fall) begin
                        cnt <= '0;
                        if (sh[0]) begin
                            state      <= ST_RDATA;
                            tx         <= rd_byte;
                            rd_cur_idx <= rd_load_idx;
                        end else begin
                            state <= ST_SUB;
                        end
                    end
                end
                ST_SUB_ACK, ST_WDATA_ACK: begin
                    if (ev.fall) begin
                        state <= ST_WDATA;
                        cnt   <= '0;
                    end
                end
                ST_RDATA: begin
                    if (ev.rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (byte_done) begin
                        state <= ST_RACK;
                    end else if (ev.fall) begin
                        tx <= {tx[6:0], 1'b1};
                    end
                end
                ST_RACK: begin
                    if (ev.rise) begin
                        nack_q <= ev.sda;
                    end else if (ev.fall) begin
                        if (nack_q) begin
                            state <= ST_IDLE;
                        end else begin
                            state      <= ST_RDATA;
                            tx         <= rd_byte;
                            rd_cur_idx <= rd_load_idx;
                            cnt        <= '0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_release_after_stop_R11: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe)
        else $error("SDA still driven after STOP");

    assert_load_enters_read_R6: assert property (@(posedge clk) disable iff (rst)
        rd_load |=> rd_busy)
        else $error("read byte loaded without entering read phase");

    assert_no_write_while_reading_R3: assert property (@(posedge clk) disable iff (rst)
        rd_busy |-> !wr_en)
        else $error("write strobe during read transfer");

endmodule

// File: rtl/vid_adc_result_bank.sv
module vid_adc_result_bank
    import vid_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flyback,
    input  logic [SET_W-1:0] adc_code,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_idx,
    output logic [CH_W-1:0]  adc_ch,
    output adc_slot_t        slot_o [NUM_ADC]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            adc_ch <= '0;
        end else if (flyback) begin
            adc_ch <= (adc_ch == CH_W'(NUM_ADC - 1)) ? '0 : adc_ch + CH_W'(1);
        end
    end

    for (genvar c = 0; c < NUM_ADC; c++) begin : g_ch
        adc_slot_t q;
        logic      hit;
        assign hit = acc_valid && (acc_idx == IDX_W'(c + 1));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (flyback && adc_ch == CH_W'(c)) begin
                q.dv   <= !hit;
                q.code <= adc_code;
            end
        end

        assign slot_o[c] = q;
    end

    assert_ch_toggles_R9: assert property (@(posedge clk) disable iff (rst)
        flyback |=> (adc_ch != $past(adc_ch)))
        else $error("channel select did not advance at flyback");

    assert_collide_clears_dv_R10: assert property (@(posedge clk) disable iff (rst)
        (flyback && acc_valid && acc_idx == IDX_W'(adc_ch) + IDX_W'(1))
            |=> !slot_o[$past(adc_ch)].dv)
        else $error("collided store left data valid set");

    assert_clean_sets_dv_R10: assert property (@(posedge clk) disable iff (rst)
        (flyback && !acc_valid) |=> slot_o[$past(adc_ch)].dv)
        else $error("clean store did not set data valid");

endmodule

// File: rtl/vid_i2c_regfile.sv
module vid_i2c_regfile
    import vid_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_strap,
    input  logic       power_fail,
    input  logic       field_flyback,
    input  logic [5:0] adc_code,
    output logic       adc_ch,
    output logic       ctl_stb,
    output logic       ctl_ams,
    output logic       ctl_fhs,
    output logic       ctl_cfs,
    output logic [5:0] peak_lvl,
    output logic [5:0] steep_lvl,
    output logic [5:0] coring_lvl,
    output logic [5:0] width_lvl
);

    line_ev_t         ev;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic             rd_load;
    logic [IDX_W-1:0] rd_load_idx;
    logic             rd_busy;
    logic [IDX_W-1:0] rd_cur_idx;
    logic [7:0]       rd_byte;
    logic             pdd_q;
    ctl_bits_t        ctl_q;
    logic [SET_W-1:0] set_q [1:NUM_WR-1];
    adc_slot_t        slot [NUM_ADC];
    logic [CH_W-1:0]  ch_sel;

    vid_i2c_line_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    vid_i2c_slave_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .strap       (addr_strap),
        .rd_byte     (rd_byte),
        .sda_oe      (sda_oe),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .rd_load     (rd_load),
        .rd_load_idx (rd_load_idx),
        .rd_busy     (rd_busy),
        .rd_cur_idx  (rd_cur_idx)
    );

    vid_adc_result_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .flyback   (field_flyback),
        .adc_code  (adc_code),
        .acc_valid (rd_load || rd_busy),
        .acc_idx   (rd_load ? rd_load_idx : rd_cur_idx),
        .adc_ch    (ch_sel),
        .slot_o    (slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en && wr_idx == SUB_CTL) begin
            ctl_q <= wr_data[3:0];
        end
    end

    for (genvar g = 1; g < NUM_WR; g++) begin : g_set
        logic [SET_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                q <= wr_data[SET_W-1:0];
            end
        end
        assign set_q[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pdd_q <= 1'b1;
        end else if (power_fail) begin
            pdd_q <= 1'b1;
        end else if (rd_load && rd_load_idx == '0) begin
            pdd_q <= 1'b0;
        end
    end

    always_comb begin
        rd_byte = {4'b0000, DEVICE_ID, pdd_q};
        for (int k = 0; k < NUM_ADC; k++) begin
            if (rd_load_idx == IDX_W'(k + 1)) begin
                rd_byte = {1'b0, slot[k]};
            end
        end
    end

    assign adc_ch     = ch_sel[0];
    assign ctl_stb    = ctl_q.stb;
    assign ctl_ams    = ctl_q.ams;
    assign ctl_fhs    = ctl_q.fhs;
    assign ctl_cfs    = ctl_q.cfs;
    assign peak_lvl   = set_q[SUB_PEAK];
    assign steep_lvl  = set_q[SUB_STEEP];
    assign coring_lvl = set_q[SUB_CORE];
    assign width_lvl  = set_q[SUB_WIDTH];

    assert_pdd_set_R7: assert property (@(posedge clk) disable iff (rst)
        power_fail |=> pdd_q)
        else $error("power-loss flag not set");

    assert_pdd_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_load && rd_load_idx == '0 && !power_fail) |=> !pdd_q)
        else $error("power-loss flag survived a status read");

    assert_ctl_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctl_q))
        else $error("control bits changed without a write");

endmodule

// File: tb/vid_i2c_regfile_tb_top.sv
`timescale 1ns/1ps
module vid_i2c_regfile_tb_top;

    localparam int Q = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, scl_m, sda_m, strap, pfail, fly;
    logic [5:0] code;
    logic sda_oe, adc_ch, c_stb, c_ams, c_fhs, c_cfs;
    logic [5:0] peak, steep, cor, wid;
    logic sda_line;
    assign sda_line = sda_m & ~sda_oe;

    vid_i2c_regfile dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_strap(strap), .power_fail(pfail), .field_flyback(fly), .adc_code(code),
        .adc_ch(adc_ch), .ctl_stb(c_stb), .ctl_ams(c_ams), .ctl_fhs(c_fhs), .ctl_cfs(c_cfs),
        .peak_lvl(peak), .steep_lvl(steep), .coring_lvl(cor), .width_lvl(wid)
    );

    int total = 0;
    int bad   = 0;

    logic [3:0] m_ctl;
    logic [5:0] m_set [1:4];
    logic       m_pdd;
    logic       m_ch;
    logic       m_dv   [2];
    logic [5:0] m_code [2];
    bit         model_valid = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_valid && !rst) begin
            total++;
            if ({c_cfs, c_fhs, c_ams, c_stb} !== m_ctl || peak !== m_set[1] ||
                steep !== m_set[2] || cor !== m_set[3] || wid !== m_set[4] || adc_ch !== m_ch) begin
                bad++;
                $display("FAIL R4 R9 per-cycle actual=%h_%h_%h_%h_%h_%h expected=%h_%h_%h_%h_%h_%h",
                         {c_cfs, c_fhs, c_ams, c_stb}, peak, steep, cor, wid, adc_ch,
                         m_ctl, m_set[1], m_set[2], m_set[3], m_set[4], m_ch);
            end
        end
    end

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; clks(Q); scl_m = 1'b1; clks(2*Q); scl_m = 1'b0; clks(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; clks(Q); scl_m = 1'b1; clks(Q); b = sda_line; clks(Q); scl_m = 1'b0; clks(Q);
    endtask

    task automatic do_start();
        sda_m = 1'b1; clks(Q); scl_m = 1'b1; clks(Q); sda_m = 1'b0; clks(Q); scl_m = 1'b0; clks(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; clks(Q); scl_m = 1'b1; clks(Q); sda_m = 1'b1; clks(2*Q);
    endtask

    task automatic pulse_fly(input logic [5:0] v);
        code = v; fly = 1'b1; clks(1); fly = 1'b0;
    endtask

    task automatic model_fly(input logic [5:0] v, input logic collide);
        m_code[m_ch] = v; m_dv[m_ch] = !collide; m_ch = !m_ch;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(x);
        ack = !x;
    endtask

    task automatic recv_byte(input logic mack, input bit fly_here, input logic [5:0] fv, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            bit_in(b[i]);
            if (fly_here && i == 4) pulse_fly(fv);
        end
        bit_out(!mack);
    endtask

    task automatic wr_and_check(input string req, input logic [7:0] a, input logic [7:0] sub,
                                input logic [31:0] d, input int n, input logic [5:0] exp_acks);
        logic [5:0] acks;
        logic k;
        model_valid = 0;
        acks = '0;
        do_start();
        send_byte(a, k); acks[0] = k;
        if (acks[0]) begin send_byte(sub, k); acks[1] = k; end
        for (int i = 0; i < n; i++) begin
            if (acks[i+1]) begin send_byte(d[8*i +: 8], k); acks[i+2] = k; end
        end
        do_stop();
        if (a[7:1] == {strap, 1'b1, strap, 4'b0000} && !a[0] && sub <= 8'd4) begin
            for (int i = 0; i < n; i++) begin
                if (sub + i <= 4) begin
                    if (sub + i == 0) m_ctl = d[8*i +: 4];
                    else m_set[sub + i] = d[8*i +: 6];
                end
            end
        end
        chk(req, "ack pattern", {26'd0, acks}, {26'd0, exp_acks});
        clks(2);
        model_valid = 1;
    endtask

    task automatic rd_and_check(input string req, input int n, input int fly_at, input logic [5:0] fv);
        logic [7:0] exp [4];
        logic [7:0] got;
        logic k;
        int idx;
        model_valid = 0;
        for (int i = 0; i < n; i++) begin
            idx = i % 3;
            if (idx == 0) begin
                exp[i] = {7'd0, m_pdd}; m_pdd = 1'b0;
            end else begin
                exp[i] = {1'b0, m_dv[idx-1], m_code[idx-1]};
            end
            if (i == fly_at) model_fly(fv, (int'(m_ch) + 1) == idx);
        end
        do_start();
        send_byte({strap, 1'b1, strap, 4'b0000, 1'b1}, k);
        chk(req, "read address ack", {31'd0, k}, 32'd1);
        if (k) begin
            for (int i = 0; i < n; i++) begin
                recv_byte(i < n - 1, i == fly_at, fv, got);
                chk(req, $sformatf("read byte %0d", i), {24'd0, got}, {24'd0, exp[i]});
            end
        end
        do_stop();
        chk("R6", "SDA released after read", {31'd0, sda_oe}, 32'd0);
        clks(2);
        model_valid = 1;
    endtask

    task automatic fly_idle(input logic [5:0] v);
        model_valid = 0;
        pulse_fly(v);
        model_fly(v, 1'b0);
        clks(1);
        model_valid = 1;
    endtask

    task automatic pwr_pulse();
        pfail = 1'b1; clks(1); pfail = 1'b0; m_pdd = 1'b1;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic k;
        logic [7:0] got;
        rst = 1; scl_m = 1; sda_m = 1; strap = 0; pfail = 0; fly = 0; code = '0;
        m_ctl = '0; m_pdd = 1'b1; m_ch = 1'b0;
        for (int i = 1; i <= 4; i++) m_set[i] = '0;
        for (int i = 0; i < 2; i++) begin m_dv[i] = 1'b0; m_code[i] = '0; end
        clks(10); rst = 0; clks(2);

        // R5: reset state
        chk("R5", "control bits", {28'd0, c_cfs, c_fhs, c_ams, c_stb}, 32'd0);
        chk("R5", "settings", {8'd0, peak, steep, cor, wid}, 32'd0);
        chk("R5", "sda idle", {31'd0, sda_oe}, 32'd0);
        chk("R9", "channel after reset", {31'd0, adc_ch}, 32'd0);
        model_valid = 1;

        // R1 R2 R4: control byte, upper bits dropped
        wr_and_check("R1", 8'h40, 8'h00, 32'h000000F5, 1, 6'b000111);
        chk("R4", "control fields", {28'd0, c_cfs, c_fhs, c_ams, c_stb}, 32'h5);

        // R3 R4: auto-increment across all settings
        wr_and_check("R3", 8'h40, 8'h01, 32'hC53F2211, 4, 6'b111111);
        chk("R4", "settings mapped", {8'd0, peak, steep, cor, wid}, {8'd0, 6'h11, 6'h22, 6'h3F, 6'h05});

        // R3: run past the last subaddress
        wr_and_check("R3", 8'h40, 8'h03, 32'h002A0201, 3, 6'b001111);
        chk("R3", "no wrap to control", {28'd0, c_cfs, c_fhs, c_ams, c_stb}, 32'h5);

        // R2: out-of-map subaddress
        wr_and_check("R2", 8'h40, 8'h05, 32'h0000003F, 1, 6'b000001);

        // R1: other strap's address
        wr_and_check("R1", 8'hE0, 8'h01, 32'h00000000, 1, 6'b000000);

        // R6 R7 R8: read from zero with wrap
        rd_and_check("R7", 4, -1, 6'h00);

        // R7: power loss sets flag again, read clears
        pwr_pulse();
        rd_and_check("R7", 1, -1, 6'h00);
        rd_and_check("R7", 1, -1, 6'h00);

        // R9 R8: flyback stores alternate between channels
        fly_idle(6'h2A);
        fly_idle(6'h15);
        rd_and_check("R9", 3, -1, 6'h00);

        // R10: store into register while it is on the bus
        rd_and_check("R10", 3, 1, 6'h33);
        rd_and_check("R10", 3, -1, 6'h00);

        // R10: store into the other register before it is loaded
        rd_and_check("R10", 3, 1, 6'h0C);

        // R1: strap high moves the address
        strap = 1'b1;
        wr_and_check("R1", 8'hE0, 8'h04, 32'h0000003E, 1, 6'b000111);
        wr_and_check("R1", 8'h40, 8'h04, 32'h00000011, 1, 6'b000000);

        // R11 R6: repeated START after a subaddress still reads from zero
        pwr_pulse();
        model_valid = 0;
        do_start();
        send_byte(8'hE0, k);
        send_byte(8'h02, k);
        do_start();
        send_byte(8'hE1, k);
        chk("R11", "restart address ack", {31'd0, k}, 32'd1);
        recv_byte(1'b0, 1'b0, 6'h00, got);
        m_pdd = 1'b0;
        chk("R6", "restart read starts at status", {24'd0, got}, 32'h01);
        do_stop();
        clks(2);
        model_valid = 1;

        // R11: STOP inside a data byte stores nothing
        model_valid = 0;
        do_start();
        send_byte(8'hE0, k);
        send_byte(8'h01, k);
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        do_stop();
        chk("R11", "released after abort", {31'd0, sda_oe}, 32'd0);
        chk("R11", "peak kept after abort", {26'd0, peak}, 32'h11);
        clks(2);
        model_valid = 1;
        clks(20);

        summary();
        $finish;
    end

endmodule